// File: doc/BRIEF.md
# 16 kHz Clock-Enable Generator

This block turns a 13 MHz reference rate into a 16 kHz event stream. It runs on one fast counting clock and is told when to count by qualifying strobes: one strobe at the reference rate, one at twice that rate, and one at four times that rate. Producing those strobes (edge doubling, multiplication) happens outside the block. A 3-bit mode input picks how the 16 kHz rate is derived. The choices are a phase accumulator, a divider that alternates two ratios, an exact divide of the doubled rate with either a balanced or a top-bit waveform, and an exact divide of the quadrupled rate that drives a toggle flop.

Every mode gives two outputs. The first is a one-cycle event pulse, used as a clock enable by downstream logic. The second is a square-wave level whose duty cycle and edge jitter depend on the method chosen. A state machine tracks the active method. Whenever the mode code changes, it passes through a clearing state, so each method starts from zero counts with both outputs low.

States: `S_CLEAR` (counters held at zero, outputs low), `S_ACC`, `S_DUAL`, `S_EXBAL`, `S_EXMSB`, `S_TOG`. The transitions are:
- reset to `S_CLEAR`;
- `S_CLEAR` to the state that matches the mode code, or stay in `S_CLEAR` for an unused code;
- any running state to `S_CLEAR` when the mode code no longer matches it.

Top module: `clken16k_gen`

## Requirements
- R1: Mode code 0 (accumulator): on each cycle with `ref_ce_i` high, a 21-bit accumulator adds 2581 modulo 2^21. `wave_o` follows the accumulator's top bit one cycle later, and `pulse_o` marks each 0-to-1 step of `wave_o`. With the strobe always high, the pulse intervals are 812 and 813 cycles, as the modular sum dictates.
- R2: Mode code 1 (dual modulus): events come alternately after 812 and 813 `ref_ce_i` ticks, starting with 812. `wave_o` is high for the first 406 ticks of each interval.
- R3: Mode code 2 (exact, balanced): one event every 1625 `dbl_ce_i` ticks. `wave_o` is high for 812 ticks and low for 813 ticks of each period.
- R4: Mode code 3 (exact, top bit): one event every 1625 `dbl_ce_i` ticks. `wave_o` is bit 10 of the 11-bit tick counter: high for 601 of 1625 ticks, and high when the pulse is issued.
- R5: Mode code 4 (toggle): every 1625 `quad_ce_i` ticks, `wave_o` toggles. This gives 1625 ticks high and 1625 ticks low. `pulse_o` fires on each rising toggle, together with `wave_o` going high.
- R6: `pulse_o` is never high for two consecutive clock cycles.
- R7: When the clock edge first samples a changed mode code, both outputs go low at that edge and all counters restart. In mode 2 with the strobe always high, the first pulse then follows 1626 edges later.
- R8: While `rst_n` is low, both outputs are low.
- R9: Unused mode codes 5 to 7 keep both outputs low.
- R10: Only ticks of the strobe that belongs to the active mode advance the count. Clock cycles with that strobe low stretch the period by exactly their number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Method select (0 accumulator, 1 dual modulus, 2 exact balanced, 3 exact top bit, 4 toggle) |
| ref_ce_i | input | 1 | Reference-rate (13 MHz) strobe |
| dbl_ce_i | input | 1 | Doubled-rate (26 MHz) strobe |
| quad_ce_i | input | 1 | Quadrupled-rate (52 MHz) strobe |
| pulse_o | output | 1 | One-cycle 16 kHz event pulse |
| wave_o | output | 1 | 16 kHz square-wave level |

## Verification
The hardest situation to reach from the ports is a mode change while the outgoing method holds `wave_o` high. Only then does forcing the output low at the clearing edge show up as a visible step. The bench waits in toggle mode for a rising-toggle pulse, switches to exact balanced mode on the very next cycle, and checks both the immediate low level and the 1627-cycle wait for the first new pulse. The accumulator's uneven 812/813 spacing comes from a modular sum, so the bench replays that sum itself to find the expected pulse intervals and high times.

// File: rtl/clken16k_pkg.sv
package clken16k_pkg;

    typedef enum logic [2:0] {
        S_CLEAR = 3'd0,
        S_ACC   = 3'd1,
        S_DUAL  = 3'd2,
        S_EXBAL = 3'd3,
        S_EXMSB = 3'd4,
        S_TOG   = 3'd5
    } gen_state_e;

    localparam logic [2:0] MODE_ACC   = 3'd0;
    localparam logic [2:0] MODE_DUAL  = 3'd1;
    localparam logic [2:0] MODE_EXBAL = 3'd2;
    localparam logic [2:0] MODE_EXMSB = 3'd3;
    localparam logic [2:0] MODE_TOG   = 3'd4;

    function automatic gen_state_e mode_target(input logic [2:0] m);
        unique case (m)
            MODE_ACC:   return S_ACC;
            MODE_DUAL:  return S_DUAL;
            MODE_EXBAL: return S_EXBAL;
            MODE_EXMSB: return S_EXMSB;
            MODE_TOG:   return S_TOG;
            default:    return S_CLEAR;
        endcase
    endfunction

endpackage

// File: rtl/clken16k_accum.sv
module clken16k_accum #(
    parameter int ACC_W    = 21,
    parameter int ACC_STEP = 2581
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic msb
);
    localparam logic [ACC_W-1:0] STEP_V = ACC_W'(ACC_STEP);

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_q + STEP_V;
        end
    end

    assign msb = acc_q[ACC_W-1];
endmodule

// File: rtl/clken16k_count.sv
module clken16k_count #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = en && !clr && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/clken16k_gen.sv
module clken16k_gen
    import clken16k_pkg::*;
#(
    parameter int ACC_W     = 21,
    parameter int ACC_STEP  = 2581,
    parameter int DIV_LO    = 812,
    parameter int DIV_HI    = 813,
    parameter int EXACT_DIV = 1625,
    parameter int BAL_HIGH  = 812
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       ref_ce_i,
    input  logic       dbl_ce_i,
    input  logic       quad_ce_i,
    output logic       pulse_o,
    output logic       wave_o
);
    localparam int CNT_W = $clog2(EXACT_DIV);
    localparam logic [CNT_W-1:0] LAST_LO    = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI    = CNT_W'(DIV_HI - 1);
    localparam logic [CNT_W-1:0] LAST_EXACT = CNT_W'(EXACT_DIV - 1);
    localparam logic [CNT_W-1:0] DUAL_HIGH  = CNT_W'(DIV_LO / 2);
    localparam logic [CNT_W-1:0] BAL_LIM    = CNT_W'(BAL_HIGH);

    gen_state_e       state_q, state_n, target;
    logic             clr;
    logic             acc_msb;
    logic             cnt_en, wrap, phase_q;
    logic [CNT_W-1:0] cnt, last;

    // state register and transitions
    assign target = mode_target(mode_i);
    assign clr    = (state_q == S_CLEAR) || (target != state_q);

    always_comb begin
        if (state_q == S_CLEAR) begin
            state_n = target;
        end else if (target != state_q) begin
            state_n = S_CLEAR;
        end else begin
            state_n = state_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_CLEAR;
        end else begin
            state_q <= state_n;
        end
    end

    // counting datapath
    always_comb begin
        cnt_en = 1'b0;
        last   = LAST_EXACT;
        unique case (state_q)
            S_DUAL: begin
                cnt_en = ref_ce_i;
                last   = phase_q ? LAST_HI : LAST_LO;
            end
            S_EXBAL, S_EXMSB: cnt_en = dbl_ce_i;
            S_TOG:            cnt_en = quad_ce_i;
            default:          cnt_en = 1'b0;
        endcase
    end

    clken16k_accum #(.ACC_W(ACC_W), .ACC_STEP(ACC_STEP)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (ref_ce_i && state_q == S_ACC),
        .msb   (acc_msb)
    );

    clken16k_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (cnt_en),
        .last  (last),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= 1'b0;
        end else if (state_q == S_DUAL && wrap) begin
            phase_q <= ~phase_q;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pulse_o <= 1'b0;
            wave_o  <= 1'b0;
        end else begin
            unique case (state_q)
                S_ACC: begin
                    wave_o  <= acc_msb;
                    pulse_o <= acc_msb && !wave_o;
                end
                S_DUAL: begin
                    wave_o  <= (cnt < DUAL_HIGH);
                    pulse_o <= wrap;
                end
                S_EXBAL: begin
                    wave_o  <= (cnt < BAL_LIM);
                    pulse_o <= wrap;
                end
                S_EXMSB: begin
                    wave_o  <= cnt[CNT_W-1];
                    pulse_o <= wrap;
                end
                S_TOG: begin
                    wave_o  <= wave_o ^ wrap;
                    pulse_o <= wrap && !wave_o;
                end
                default: begin
                    wave_o  <= 1'b0;
                    pulse_o <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/clken16k_chk.sv
module clken16k_chk
    import clken16k_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       pulse_o,
    input logic       wave_o
);
    a_r6_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    a_r7_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_i) |=> (!pulse_o && !wave_o));

    a_r1_acc_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && mode_i == MODE_ACC && pulse_o) |-> wave_o);

    a_r2_dual_pulse_wave_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && mode_i == MODE_DUAL && pulse_o) |-> !wave_o);

    a_r4_msb_pulse_wave_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && mode_i == MODE_EXMSB && pulse_o) |-> wave_o);

    a_r5_toggle_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && mode_i == MODE_TOG && pulse_o) |-> wave_o);

    a_r9_unused_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && mode_i > MODE_TOG) |=> (!pulse_o && !wave_o));
endmodule

bind clken16k_gen clken16k_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .pulse_o (pulse_o),
    .wave_o  (wave_o)
);

// File: tb/clken16k_gen_tb.sv
module clken16k_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       ref_ce_i = 1'b1;
    logic       dbl_ce_i = 1'b1;
    logic       quad_ce_i = 1'b1;
    logic       pulse_o, wave_o;

    int total = 0;
    int bad = 0;
    localparam int LIMIT = 8000;

    always #2.5 clk = ~clk;

    clken16k_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .ref_ce_i  (ref_ce_i),
        .dbl_ce_i  (dbl_ce_i),
        .quad_ce_i (quad_ce_i),
        .pulse_o   (pulse_o),
        .wave_o    (wave_o)
    );

    // {mode, first interval, second interval, high length}
    localparam int NVEC = 4;
    localparam int VEC [NVEC][4] = '{
        '{1,  813,  812,  406},   // R2
        '{2, 1625, 1625,  812},   // R3
        '{3, 1625, 1625,  601},   // R4
        '{4, 3250, 3250, 1625}    // R5
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse_o && n < LIMIT);
    endtask

    task automatic high_len(output int n);
        int guard = 0;
        while (wave_o && guard < LIMIT) begin @(negedge clk); guard++; end
        while (!wave_o && guard < 2 * LIMIT) begin @(negedge clk); guard++; end
        n = 0;
        while (wave_o && n < LIMIT) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n, i1, i2, hl, seen;
        int rise [5];
        int fall [5];
        int nr;
        logic [20:0] acc;
        logic prev;

        repeat (4) @(negedge clk);
        check("R8 reset pulse", int'(pulse_o), 0);
        check("R8 reset wave", int'(wave_o), 0);
        rst_n = 1'b1;

        // R1 model: accumulator top-bit rise/fall indices
        acc = '0; prev = 1'b0; nr = 0;
        for (int k = 1; k < 5000 && nr < 5; k++) begin
            acc = acc + 21'd2581;
            if (acc[20] && !prev) rise[nr] = k;
            if (!acc[20] && prev) begin fall[nr] = k; nr++; end
            prev = acc[20];
        end
        mode_i = 3'd0;
        wait_pulse(n);
        check("R1 first pulse", n, rise[0] + 2);
        wait_pulse(i1);
        check("R1 interval a", i1, rise[1] - rise[0]);
        wait_pulse(i2);
        check("R1 interval b", i2, rise[2] - rise[1]);
        high_len(hl);
        check("R1 high length", hl, fall[3] - rise[3]);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            mode_i = 3'(VEC[v][0]);
            wait_pulse(n);
            wait_pulse(i1);
            check($sformatf("R%0d interval a", VEC[v][0] + 1), i1, VEC[v][1]);
            @(negedge clk);
            check("R6 pulse width", int'(pulse_o), 0);
            wait_pulse(i2);
            check($sformatf("R%0d interval b", VEC[v][0] + 1), i2 + 1, VEC[v][2]);
            high_len(hl);
            check($sformatf("R%0d high length", VEC[v][0] + 1), hl, VEC[v][3]);
        end

        // R7: switch from toggle (wave just went high) to exact balanced
        wait_pulse(n);
        check("R7 wave high before switch", int'(wave_o), 1);
        mode_i = 3'd2;
        @(negedge clk);
        check("R7 wave cleared", int'(wave_o), 0);
        check("R7 pulse cleared", int'(pulse_o), 0);
        wait_pulse(n);
        check("R7 first pulse after change", n + 1, 1627);

        // R10: strobe gap stretches the period
        @(negedge clk);
        repeat (9) @(negedge clk);
        dbl_ce_i = 1'b0;
        repeat (100) @(negedge clk);
        dbl_ce_i = 1'b1;
        wait_pulse(n);
        check("R10 stretched interval", n + 110, 1725);
        ref_ce_i = 1'b0; quad_ce_i = 1'b0;
        wait_pulse(n);
        check("R10 other strobes ignored", n, 1625);
        ref_ce_i = 1'b1; quad_ce_i = 1'b1;

        // R9: unused code
        mode_i = 3'd6;
        seen = 0;
        repeat (4000) begin
            @(negedge clk);
            if (pulse_o || wave_o) seen++;
        end
        check("R9 unused code quiet", seen, 0);

        // R8: reset while wave high
        mode_i = 3'd3;
        wait_pulse(n);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset mid-run wave", int'(wave_o), 0);
        check("R8 reset mid-run pulse", int'(pulse_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(190000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule